// File: doc/BRIEF.md
# Modem Frame Receive Sequencer

This block is a host-side controller that walks a four-level FSK modem data pump through the reception of a single frame. The frame is made of four blocks: a station identifier of 3 bytes, a header of 10 bytes, one intermediate block of 12 bytes and a final block of 8 bytes. The sequencer talks to the modem over a byte-wide register port with four addresses (data buffer, status, mode, command). It waits on the modem interrupt line and checks the status flags after every task. Each received byte is handed out on a valid/ready port, tagged with its block.

A one-cycle `start` pulse begins the frame. The sequencer programs the mode register and then waits until the carrier has been present for a run of symbol periods. It reads status to confirm that the buffer is free. It then issues four receive tasks in a fixed order: a sync search that acquires clock and level, a header read, and two intermediate/last reads. After each task it waits for the interrupt, reads status, and fetches the block's bytes one at a time. Any failed check or interrupt timeout ends the frame at once. The sequencer then sets a sticky error with a 3-bit code for the failing step and returns to idle.

States: `S_IDLE`, `S_SET_MODE`, `S_CARRIER`, `S_CHK_FREE`, `S_ISSUE`, `S_WAIT_IRQ`, `S_CHK_STAT`, `S_FETCH`, `S_OFFER`.

Transitions:
- `S_IDLE` goes to `S_SET_MODE` on start.
- `S_SET_MODE` goes to `S_CARRIER`.
- `S_CARRIER` goes to `S_CHK_FREE` once the carrier is qualified.
- `S_CHK_FREE` goes to `S_ISSUE` if the buffer is free, otherwise to `S_IDLE` with code 1.
- `S_ISSUE` goes to `S_WAIT_IRQ`.
- `S_WAIT_IRQ` goes to `S_CHK_STAT` on the interrupt, or to `S_IDLE` with code 7 on expiry.
- `S_CHK_STAT` goes to `S_FETCH` if the flags pass, otherwise to `S_IDLE` with the step code.
- `S_FETCH` goes to `S_OFFER`.
- `S_OFFER`, on the handshake, goes to one of three states:
  - `S_FETCH` when more bytes remain in the block;
  - `S_ISSUE` when the block ends and it is not the last;
  - `S_IDLE` with `done` when the last block ends.

Top module: `fsk_frame_rx_seq`

## Requirements
- R1: A `start` accepted in idle produces exactly one write of the mode byte to address 2. Its bit 0 (interrupt enable) is 1, bits 1 to 4 (transmit select, eye output, power save, symbol interrupt) are 0, bit 5 equals `inv_sym`, and bits 6 and 7 are 0. A `start` while busy is ignored.
- R2: No status read occurs until `carrier` has been high on 8 consecutive `sym_tick` cycles. A low `carrier` restarts the count.
- R3: The first status read (address 1) must show bit 6 (buffer free) at 1. Otherwise the frame aborts with code 1 before any command write.
- R4: The commands written to address 3 are, in order, 0x19, 0x02, 0x03 and 0x03. 0x19 is the sync search task, with bit 3 (clock acquire) and bit 4 (level acquire) set. 0x02 is the header read and 0x03 is the intermediate/last read.
- R5: After each command the sequencer waits for `modem_irq` and then reads status. The status must show bit 7 (IRQ) at 1, bit 6 (buffer free) at 1 and bit 4 (overflow) at 0. A failure aborts with code 2 (sync/ID), 3 (header), 4 (intermediate) or 5 (last).
- R6: Status bit 5 (CRC error) aborts the frame when set after the sync, header and last tasks. It is ignored after the intermediate task.
- R7: If `modem_irq` stays low for more than `irq_wait_limit` cycles after a command, the frame aborts with code 7.
- R8: The bytes are read from address 0 and offered in this order: 3 bytes with tag 0, 10 with tag 1, 12 with tag 2 and 8 with tag 3. `out_last` is high only on the 33rd byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R10: `err` and `err_code` stay set after an abort until the next accepted `start` clears them. `done` pulses for one cycle when the frame completes, and `busy` is high from start until the return to idle.
- R11: `bus_rd` and `bus_wr` are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a frame (pulse) |
| inv_sym | input | 1 | Value for the symbol-inversion mode bit |
| carrier | input | 1 | Carrier-present indication |
| sym_tick | input | 1 | One pulse per symbol period |
| irq_wait_limit | input | TMO_W | Cycles allowed for each interrupt wait |
| modem_irq | input | 1 | Modem interrupt, active high |
| bus_rdata | input | 8 | Modem register read data, valid in the read cycle |
| bus_addr | output | 2 | Register address: 0 data, 1 status, 2 mode, 3 command |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | 8 | Register write data |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Received byte |
| out_tag | output | 2 | Block tag: 0 ID, 1 header, 2 intermediate, 3 last |
| out_last | output | 1 | Final byte of the frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse on a completed frame |
| err | output | 1 | Sticky abort flag |
| err_code | output | 3 | Failing step: 1 start, 2 sync, 3 header, 4 intermediate, 5 last, 7 timeout |

## Verification
The assertions assume that the modem returns its read data combinationally in the same cycle as `bus_rd`. They also assume that `modem_irq` falls only when status is read, and that `out_ready` never depends combinationally on `out_valid`. The bench's behavioural modem stub keeps to this. It raises its interrupt a few cycles after each command write and clears it on a status read. The stub corrupts exactly one chosen status read per frame, or withholds one interrupt. `out_ready` is driven only at the falling edge, from a cycle counter.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_SET_MODE, S_CARRIER, S_CHK_FREE, S_ISSUE,
        S_WAIT_IRQ, S_CHK_STAT, S_FETCH, S_OFFER
    } seq_state_t;

    typedef enum logic [1:0] {
        TAG_ID = 2'd0, TAG_HDR = 2'd1, TAG_MID = 2'd2, TAG_END = 2'd3
    } blk_tag_t;

    // register addresses
    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_MODE = 2'd2;
    localparam logic [1:0] REG_CMD  = 2'd3;

    // status bit positions
    localparam int ST_IRQ  = 7;
    localparam int ST_FREE = 6;
    localparam int ST_CRC  = 5;
    localparam int ST_OVF  = 4;

    // mode bit positions
    localparam int MD_IRQ_EN = 0;
    localparam int MD_INV    = 5;

    // command bytes
    localparam logic [7:0] CMD_SYNC = 8'h19;
    localparam logic [7:0] CMD_HDR  = 8'h02;
    localparam logic [7:0] CMD_BLK  = 8'h03;

    // abort codes
    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_NOFREE  = 3'd1;
    localparam logic [2:0] ERR_STEP0   = 3'd2;
    localparam logic [2:0] ERR_TIMEOUT = 3'd7;
endpackage

// File: rtl/fsk_carrier_qual.sv
module fsk_carrier_qual #(
    parameter int SYMS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier,
    input  logic sym_tick,
    output logic ok
);
    localparam int CW = $clog2(SYMS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!carrier) begin
            cnt <= '0;
        end else if (sym_tick && cnt != CW'(SYMS)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ok = carrier && (cnt == CW'(SYMS));

    // R2
    carrier_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier) |=> !ok);
endmodule

// File: rtl/fsk_wait_timer.sv
module fsk_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    assign expired = run && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsk_frame_rx_seq.sv
module fsk_frame_rx_seq
    import fsk_rx_pkg::*;
#(
    parameter int ID_BYTES     = 3,
    parameter int HDR_BYTES    = 10,
    parameter int MID_BYTES    = 12,
    parameter int END_BYTES    = 8,
    parameter int CARRIER_SYMS = 8,
    parameter int TMO_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             inv_sym,
    input  logic             carrier,
    input  logic             sym_tick,
    input  logic [TMO_W-1:0] irq_wait_limit,
    input  logic             modem_irq,
    input  logic [7:0]       bus_rdata,
    output logic [1:0]       bus_addr,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [7:0]       bus_wdata,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic [1:0]       out_tag,
    output logic             out_last,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [2:0]       err_code
);
    localparam int MAX_AB = (ID_BYTES > HDR_BYTES) ? ID_BYTES : HDR_BYTES;
    localparam int MAX_CD = (MID_BYTES > END_BYTES) ? MID_BYTES : END_BYTES;
    localparam int MAX_B  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_B + 1);

    seq_state_t       state, nstate;
    blk_tag_t         step;
    logic [CNT_W-1:0] byte_cnt, blk_len;
    logic [7:0]       data_q, cmd_byte, mode_byte;
    logic             carrier_ok, tmo, stat_ok, blk_end;

    fsk_carrier_qual #(.SYMS(CARRIER_SYMS)) u_qual (
        .clk(clk), .rst_n(rst_n), .carrier(carrier),
        .sym_tick(sym_tick), .ok(carrier_ok)
    );

    fsk_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(state == S_ISSUE),
        .run(state == S_WAIT_IRQ), .limit(irq_wait_limit), .expired(tmo)
    );

    always_comb begin
        unique case (step)
            TAG_ID:  begin blk_len = CNT_W'(ID_BYTES);  cmd_byte = CMD_SYNC; end
            TAG_HDR: begin blk_len = CNT_W'(HDR_BYTES); cmd_byte = CMD_HDR;  end
            TAG_MID: begin blk_len = CNT_W'(MID_BYTES); cmd_byte = CMD_BLK;  end
            TAG_END: begin blk_len = CNT_W'(END_BYTES); cmd_byte = CMD_BLK;  end
        endcase
    end

    assign mode_byte = 8'((32'(inv_sym) << MD_INV) | (32'd1 << MD_IRQ_EN));
    assign stat_ok   = bus_rdata[ST_IRQ] && bus_rdata[ST_FREE] && !bus_rdata[ST_OVF]
                       && ((step == TAG_MID) || !bus_rdata[ST_CRC]);
    assign blk_end   = (byte_cnt + 1'b1) == blk_len;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next state and bus outputs
    always_comb begin
        nstate    = state;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = REG_DATA;
        bus_wdata = 8'h00;
        unique case (state)
            S_IDLE:     if (start) nstate = S_SET_MODE;
            S_SET_MODE: begin
                bus_wr = 1'b1; bus_addr = REG_MODE; bus_wdata = mode_byte;
                nstate = S_CARRIER;
            end
            S_CARRIER:  if (carrier_ok) nstate = S_CHK_FREE;
            S_CHK_FREE: begin
                bus_rd = 1'b1; bus_addr = REG_STAT;
                nstate = bus_rdata[ST_FREE] ? S_ISSUE : S_IDLE;
            end
            S_ISSUE: begin
                bus_wr = 1'b1; bus_addr = REG_CMD; bus_wdata = cmd_byte;
                nstate = S_WAIT_IRQ;
            end
            S_WAIT_IRQ: begin
                if (modem_irq) nstate = S_CHK_STAT;
                else if (tmo)  nstate = S_IDLE;
            end
            S_CHK_STAT: begin
                bus_rd = 1'b1; bus_addr = REG_STAT;
                nstate = stat_ok ? S_FETCH : S_IDLE;
            end
            S_FETCH: begin
                bus_rd = 1'b1; bus_addr = REG_DATA;
                nstate = S_OFFER;
            end
            S_OFFER: begin
                if (out_ready) begin
                    if (!blk_end)              nstate = S_FETCH;
                    else if (step == TAG_END)  nstate = S_IDLE;
                    else                       nstate = S_ISSUE;
                end
            end
        endcase
    end

    // datapath and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step     <= TAG_ID;
            byte_cnt <= '0;
            data_q   <= '0;
            err      <= 1'b0;
            err_code <= ERR_NONE;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    err <= 1'b0; err_code <= ERR_NONE; step <= TAG_ID;
                end
                S_CHK_FREE: if (!bus_rdata[ST_FREE]) begin
                    err <= 1'b1; err_code <= ERR_NOFREE;
                end
                S_WAIT_IRQ: if (!modem_irq && tmo) begin
                    err <= 1'b1; err_code <= ERR_TIMEOUT;
                end
                S_CHK_STAT: begin
                    byte_cnt <= '0;
                    if (!stat_ok) begin
                        err <= 1'b1; err_code <= ERR_STEP0 + 3'(step);
                    end
                end
                S_FETCH: data_q <= bus_rdata;
                S_OFFER: if (out_ready) begin
                    if (!blk_end) begin
                        byte_cnt <= byte_cnt + 1'b1;
                    end else if (step == TAG_END) begin
                        done <= 1'b1;
                    end else begin
                        step <= blk_tag_t'(step + 2'd1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_valid = (state == S_OFFER);
    assign out_data  = data_q;
    assign out_tag   = step;
    assign out_last  = (state == S_OFFER) && blk_end && (step == TAG_END);
    assign busy      = (state != S_IDLE);

    // R11
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_rd || bus_wr));
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));
    // R8
    last_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (out_tag == TAG_END));
    // R10
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(busy) && !busy && (err_code != ERR_NONE)));
    // R4
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_CMD) |->
            (bus_wdata == CMD_SYNC || bus_wdata == CMD_HDR || bus_wdata == CMD_BLK));
    // R10
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err));
endmodule

// File: tb/fsk_frame_rx_seq_bench.sv
module fsk_frame_rx_seq_bench;
    import fsk_rx_pkg::*;

    localparam int TMO_W = 16;
    localparam int TOTAL = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             start = 1'b0, inv_sym = 1'b0, carrier = 1'b1, sym_tick = 1'b0;
    logic [TMO_W-1:0] irq_wait_limit = 16'd50;
    logic             modem_irq;
    logic [7:0]       bus_rdata, bus_wdata, out_data;
    logic [1:0]       bus_addr, out_tag;
    logic             bus_rd, bus_wr, out_valid, out_last, busy, done, err;
    logic             out_ready = 1'b1;
    logic [2:0]       err_code;

    fsk_frame_rx_seq #(.TMO_W(TMO_W)) u_fsk_frame_rx_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .inv_sym(inv_sym),
        .carrier(carrier), .sym_tick(sym_tick), .irq_wait_limit(irq_wait_limit),
        .modem_irq(modem_irq), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_tag(out_tag), .out_last(out_last), .busy(busy), .done(done),
        .err(err), .err_code(err_code)
    );

    int n_tests = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // symbol tick every 4 cycles
    logic [1:0] tdiv = 2'd0;
    always @(negedge clk) begin
        tdiv     <= tdiv + 2'd1;
        sym_tick <= (tdiv == 2'd2);
    end

    // behavioural modem stub
    int         st_reads, cmd_count, mode_writes, dly, fault_read = -1, fault_kind = 0;
    bit         irq_pend, stub_clr;
    logic [7:0] dptr, mode_seen;
    logic [7:0] cmd_log [4];

    assign modem_irq = irq_pend;

    always_comb begin
        logic [7:0] st;
        st = {irq_pend, 1'b1, 1'b0, 1'b0, 4'b0000};
        if (st_reads == fault_read) begin
            case (fault_kind)
                1: st[6] = 1'b0;
                2: st[5] = 1'b1;
                3: st[4] = 1'b1;
                4: st[7] = 1'b0;
                default: ;
            endcase
        end
        if (bus_addr == 2'd1)      bus_rdata = st;
        else if (bus_addr == 2'd0) bus_rdata = 8'(int'(dptr) * 7 + 3);
        else                       bus_rdata = 8'h00;
    end

    always @(posedge clk) begin
        if (stub_clr) begin
            st_reads <= 0; cmd_count <= 0; mode_writes <= 0; dly <= 0;
            irq_pend <= 1'b0; dptr <= 8'd0; mode_seen <= 8'hFF;
            for (int i = 0; i < 4; i++) cmd_log[i] <= 8'hEE;
        end else begin
            if (dly > 1) dly <= dly - 1;
            else if (dly == 1) begin irq_pend <= 1'b1; dly <= 0; end
            if (bus_wr && bus_addr == 2'd3) begin
                if (cmd_count < 4) cmd_log[cmd_count[1:0]] <= bus_wdata;
                cmd_count <= cmd_count + 1;
                dly <= (fault_kind == 5 && cmd_count + 1 == fault_read) ? 0 : 5;
            end
            if (bus_wr && bus_addr == 2'd2) begin
                mode_seen <= bus_wdata; mode_writes <= mode_writes + 1;
            end
            if (bus_rd && bus_addr == 2'd1) begin
                st_reads <= st_reads + 1; irq_pend <= 1'b0;
            end
            if (bus_rd && bus_addr == 2'd0) dptr <= dptr + 8'd1;
        end
    end

    // output monitor and ready driver
    bit         throttle = 1'b0;
    int         rx_count, rx_bad, cyc = 0;
    logic       prev_v = 1'b0, prev_r = 1'b1;
    logic [7:0] prev_d = 8'h00;

    function automatic logic [1:0] exp_tag(input int k);
        if (k < 3)       return 2'd0;
        else if (k < 13) return 2'd1;
        else if (k < 25) return 2'd2;
        else             return 2'd3;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (stub_clr) begin
            rx_count = 0; rx_bad = 0;
        end else begin
            // R9 hold while stalled
            if (prev_v && !prev_r && (!out_valid || out_data != prev_d)) rx_bad++;
        end
        out_ready = throttle ? (cyc % 3 != 0) : 1'b1;
        if (out_valid && out_ready) begin
            // R8 data, tag and last marker
            if (out_data != 8'(rx_count * 7 + 3) || out_tag != exp_tag(rx_count)
                || out_last != (rx_count == TOTAL - 1)) rx_bad++;
            rx_count++;
        end
        prev_v = out_valid; prev_r = out_ready; prev_d = out_data;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic start_frame(input int fr, input int fk, input bit thr, input bit inv);
        @(negedge clk);
        fault_read = fr; fault_kind = fk; throttle = thr; inv_sym = inv; stub_clr = 1'b1;
        @(negedge clk);
        stub_clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_frame(output bit ended, input bit poke);
        int n = 0;
        while (busy && n < 4000) begin
            @(negedge clk);
            n++;
            start = (poke && n == 30);
        end
        start = 1'b0;
        ended = !busy;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(posedge clk); while (!sym_tick);
        end
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0] bad_read;
        logic [2:0] kind;
        logic [2:0] code;
        logic [5:0] bytes;
    } vec_t;

    // kinds: 1 free low, 2 crc set, 3 overflow set, 4 irq bit low, 5 irq line withheld
    localparam vec_t VECS [10] = '{
        '{3'd7, 3'd0, 3'd0, 6'd33},
        '{3'd0, 3'd1, 3'd1, 6'd0},
        '{3'd1, 3'd2, 3'd2, 6'd0},
        '{3'd2, 3'd3, 3'd3, 6'd3},
        '{3'd3, 3'd2, 3'd0, 6'd33},
        '{3'd3, 3'd1, 3'd4, 6'd13},
        '{3'd4, 3'd2, 3'd5, 6'd25},
        '{3'd4, 3'd4, 3'd5, 6'd25},
        '{3'd2, 3'd5, 3'd7, 6'd3},
        '{3'd1, 3'd4, 3'd2, 6'd0}
    };

    function automatic string vec_req(input vec_t v);
        if (v.kind == 3'd2)                     return "R6";
        if (v.kind == 3'd5)                     return "R7";
        if (v.kind == 3'd1 && v.bad_read == 0)  return "R3";
        return "R5";
    endfunction

    initial begin
        bit ended;
        stub_clr = 1'b1;
        repeat (3) @(negedge clk);
        // reset state
        chk(!busy && !out_valid && !err && !done, "R10 reset idle", int'(busy), 0);
        chk(!bus_rd && !bus_wr, "R11 reset bus quiet", int'(bus_rd || bus_wr), 0);
        rst_n = 1'b1;
        stub_clr = 1'b0;
        repeat (40) @(negedge clk);

        // table of vectors
        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            start_frame(int'(v.bad_read), int'(v.kind), 1'b0, 1'b0);
            finish_frame(ended, 1'b0);
            chk(ended, "R10 frame returns to idle", int'(busy), 0);
            chk(err_code == v.code, vec_req(v), int'(err_code), int'(v.code));
            chk(err == (v.code != 3'd0), "R10 err flag", int'(err), int'(v.code != 0));
            chk(rx_count == int'(v.bytes), "R8 byte count", rx_count, int'(v.bytes));
            chk(rx_bad == 0, "R8 byte content", rx_bad, 0);
            chk(done == (v.code == 3'd0), "R10 done pulse", int'(done), int'(v.code == 0));
            if (v.kind == 3'd1 && v.bad_read == 0)
                chk(cmd_count == 0, "R3 no command after busy buffer", cmd_count, 0);
        end

        // R1 R4 R9: inverted symbols, throttled consumer
        start_frame(-1, 0, 1'b1, 1'b1);
        finish_frame(ended, 1'b0);
        chk(mode_seen == 8'h21, "R1 mode byte", int'(mode_seen), 'h21);
        chk(mode_writes == 1, "R1 one mode write", mode_writes, 1);
        chk(cmd_log[0] == 8'h19 && cmd_log[1] == 8'h02, "R4 first commands",
            int'({cmd_log[0], cmd_log[1]}), 'h1902);
        chk(cmd_log[2] == 8'h03 && cmd_log[3] == 8'h03, "R4 block commands",
            int'({cmd_log[2], cmd_log[3]}), 'h0303);
        chk(rx_count == TOTAL && rx_bad == 0, "R9 throttled stream", rx_bad, 0);
        chk(done && !err, "R10 throttled done", int'(done), 1);

        // R1: start while busy ignored
        start_frame(-1, 0, 1'b0, 1'b0);
        finish_frame(ended, 1'b1);
        chk(mode_seen == 8'h01, "R1 mode byte plain", int'(mode_seen), 'h01);
        chk(mode_writes == 1 && cmd_count == 4, "R1 start while busy", cmd_count, 4);
        chk(rx_count == TOTAL && done, "R1 frame intact", rx_count, TOTAL);
        repeat (6) @(negedge clk);
        chk(!busy, "R1 no restart", int'(busy), 0);

        // R10: sticky error, cleared by next start
        start_frame(0, 1, 1'b0, 1'b0);
        finish_frame(ended, 1'b0);
        repeat (20) @(negedge clk);
        chk(err && err_code == 3'd1, "R10 sticky err", int'(err_code), 1);
        start_frame(-1, 0, 1'b0, 1'b0);
        chk(!err && err_code == 3'd0 && busy, "R10 err cleared on start", int'(err_code), 0);
        finish_frame(ended, 1'b0);

        // R2: carrier qualification with a dropout
        carrier = 1'b0;
        repeat (8) @(negedge clk);
        start_frame(-1, 0, 1'b0, 1'b0);
        carrier = 1'b1;
        wait_ticks(5);
        carrier = 1'b0;
        wait_ticks(1);
        carrier = 1'b1;
        wait_ticks(7);
        chk(st_reads == 0, "R2 no status read before 8 symbols", st_reads, 0);
        wait_ticks(1);
        repeat (3) @(negedge clk);
        chk(st_reads >= 1, "R2 status read after 8 symbols", st_reads, 1);
        finish_frame(ended, 1'b0);
        chk(done && rx_count == TOTAL, "R2 frame after carrier", rx_count, TOTAL);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule